// File: doc/BRIEF.md
# Serial EEPROM Bus Slave with Page Buffer and Write Lockout

This block is the two-wire serial slave front end of a 2048-byte nonvolatile-style memory. The memory is modelled as a register array. SCL and SDA are sampled by a much faster system clock, and SDA is driven only through an open-drain enable. The block detects start and stop conditions, matches a device select byte, and takes a word address. It returns data for sequential reads and gathers page writes in a 16-byte buffer. The buffer is committed to the array only when a stop condition closes the write.

After each commit, a programming interval of `WR_CYCLES` system clocks runs. The count is a parameter: at a 250 MHz clock the default gives about 10 ms, and a bench shortens it. During that interval the slave does not answer its own address. Two inputs gate writes. A high write-protect input makes the whole array read-only. A low supply-good input, which covers power-up before the threshold is first reached, blocks programming the same way. A blocked write is still acknowledged byte by byte, but no commit takes place and no programming interval starts.

Top module: `ee_i2c_slave`

## Requirements
- R1: After reset the slave releases SDA (`sda_oe` = 0) and stays idle until a start condition arrives.
- R2: The device select byte is acknowledged only when its bits [7:4] equal 4'b1010. Bits [3:1] carry address bits A10..A8 and bit 0 is R/W (1 = read). Any other code gets no acknowledge, and SDA stays released until the next start.
- R3: In a write, the byte after the select byte sets A7..A0. A repeated start followed by a read select returns the stored byte at that address.
- R4: Page-write data bytes are acknowledged and held in a 16-byte buffer. The low 4 address bits wrap inside the page, so a 17th or later byte overwrites the byte buffered at the same offset. The whole buffer is committed at the stop condition.
- R5: A start condition that arrives before the stop discards any buffered write data. The array keeps its old contents and no programming interval starts.
- R6: A sequential read returns consecutive bytes and wraps from 0x7FF to 0x000. The master's NACK ends the transfer, and the slave has released SDA by the stop condition.
- R7: After a commit, the slave acknowledges nothing for `WR_CYCLES` clocks and never drives SDA during that interval. Once the interval ends, it acknowledges its address again.
- R8: While the write-protect input is high, data bytes are still acknowledged but the array is left unchanged and no programming interval begins.
- R9: While the supply-good input is low, writes are blocked exactly as in R8.
- R10: SDA is only pulled low or released, and the drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus (wired-AND) |
| wp_i | input | 1 | Write protect; high makes the array read-only |
| supply_ok_i | input | 1 | High when the supply is above the reset threshold |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
Four properties are checked on every cycle. SDA is held steady while SCL is high. SDA stays released while the programming timer runs. A programming interval only ever starts when write protect was low and the supply was good. A buffered byte lands in the slot its offset selects. Other behaviours can only be shown by the bench's transactions: page wrap and overwrite, a commit made only at stop, a write abandoned by a repeated start, read rollover at the top of the array, and protected writes leaving old data in place. The bench shows these by writing page patterns into several address blocks and reading them back against a model of the array.

// File: rtl/ee_pkg.sv
package ee_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_ACK, ST_TX, ST_MACK
    } state_e;

    typedef struct packed {
        state_e      st;
        state_e      after_ack;
        logic [3:0]  bits;
        logic [7:0]  sh;
        logic        drive;
        logic        mnack;
    } link_t;

    function automatic logic is_rx(state_e s);
        return (s == ST_DEV) || (s == ST_WADDR) || (s == ST_WDATA);
    endfunction

    function automatic logic code_hit(logic [7:0] b);
        return b[7:4] == DEV_CODE;
    endfunction
endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // a data edge while the clock stays high marks a bus condition
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
    parameter int PAGE_BYTES = 16,
    localparam int PG_W = $clog2(PAGE_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        wr,
    input  logic [PG_W-1:0]             idx,
    input  logic [7:0]                  din,
    output logic [PAGE_BYTES-1:0][7:0]  data,
    output logic [PAGE_BYTES-1:0]       valid
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid <= '0;
            data  <= '0;
        end else if (wr) begin
            valid[idx] <= 1'b1;
            data[idx]  <= din;
        end
    end

    // R4: a buffered byte occupies the slot chosen by its page offset
    p_slot_written_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && !clr) |=> (valid[$past(idx)] && data[$past(idx)] == $past(din)));
endmodule

// File: rtl/ee_busy_timer.sv
module ee_busy_timer #(
    parameter int CYCLES = 2_500_000,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R7: no commit can be requested while programming is in progress
    p_start_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
    import ee_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_BYTES  = 16,
    parameter int WR_CYCLES   = 2_500_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    input  logic supply_ok_i,
    output logic sda_oe
);
    localparam int MEM_BYTES = 1 << ADDR_W;
    localparam int PG_W      = $clog2(PAGE_BYTES);
    localparam int HI_W      = ADDR_W - 8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, commit, rx_done, tx_load, wr_pend, blocked;
    logic [ADDR_W-1:0] addr;
    logic [7:0] rd_byte;
    logic [PAGE_BYTES-1:0][7:0] pb_data;
    logic [PAGE_BYTES-1:0] pb_valid;
    logic [7:0] mem [MEM_BYTES];
    link_t lk;

    ee_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign rx_done = is_rx(lk.st) && scl_fall && (lk.bits == 4'd8);
    assign tx_load = scl_fall && (((lk.st == ST_ACK) && (lk.after_ack == ST_TX)) ||
                                  ((lk.st == ST_MACK) && !lk.mnack));
    assign commit  = stop_det && wr_pend && !(blocked || wp_i || !supply_ok_i);
    assign rd_byte = mem[addr];
    assign sda_oe  = lk.drive;

    ee_page_buf #(.PAGE_BYTES(PAGE_BYTES)) pbuf_i (
        .clk(clk), .rst(rst),
        .clr(rx_done && lk.st == ST_WADDR),
        .wr(rx_done && lk.st == ST_WDATA),
        .idx(addr[PG_W-1:0]), .din(lk.sh),
        .data(pb_data), .valid(pb_valid)
    );

    ee_busy_timer #(.CYCLES(WR_CYCLES)) timer_i (
        .clk(clk), .rst(rst), .start(commit), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lk.st        <= ST_IDLE;
            lk.after_ack <= ST_IDLE;
            lk.bits      <= '0;
            lk.sh        <= '0;
            lk.drive     <= 1'b0;
            lk.mnack     <= 1'b0;
            addr         <= '0;
            wr_pend      <= 1'b0;
            blocked      <= 1'b0;
        end else if (start_det || stop_det) begin
            lk.st    <= start_det ? ST_DEV : ST_IDLE;
            lk.bits  <= '0;
            lk.drive <= 1'b0;
            wr_pend  <= 1'b0;
            blocked  <= 1'b0;
        end else begin
            if (wr_pend && (wp_i || !supply_ok_i))
                blocked <= 1'b1;
            if (is_rx(lk.st) && scl_rise && lk.bits != 4'd8) begin
                lk.sh   <= {lk.sh[6:0], sda_s};
                lk.bits <= lk.bits + 4'd1;
            end
            if (rx_done) begin
                lk.st    <= ST_ACK;
                lk.drive <= 1'b1;
                case (lk.st)
                    ST_DEV: begin
                        if (code_hit(lk.sh) && !busy) begin
                            addr[ADDR_W-1:8] <= lk.sh[HI_W:1];
                            lk.after_ack     <= lk.sh[0] ? ST_TX : ST_WADDR;
                        end else begin
                            lk.st    <= ST_IDLE;
                            lk.drive <= 1'b0;
                        end
                    end
                    ST_WADDR: begin
                        addr[7:0]    <= lk.sh;
                        lk.after_ack <= ST_WDATA;
                    end
                    default: begin
                        addr[PG_W-1:0] <= addr[PG_W-1:0] + 1'b1;
                        wr_pend        <= 1'b1;
                        lk.after_ack   <= ST_WDATA;
                    end
                endcase
            end
            if (scl_fall) begin
                case (lk.st)
                    ST_ACK: begin
                        lk.drive <= 1'b0;
                        lk.bits  <= '0;
                        lk.st    <= lk.after_ack;
                    end
                    ST_TX: begin
                        if (lk.bits == 4'd8) begin
                            lk.drive <= 1'b0;
                            lk.st    <= ST_MACK;
                        end else begin
                            lk.sh    <= {lk.sh[6:0], 1'b0};
                            lk.drive <= ~lk.sh[6];
                            lk.bits  <= lk.bits + 4'd1;
                        end
                    end
                    ST_MACK: lk.st <= ST_IDLE;
                    default: ;
                endcase
            end
            if (lk.st == ST_MACK && scl_rise)
                lk.mnack <= sda_s;
            if (tx_load) begin
                lk.sh    <= rd_byte;
                lk.drive <= ~rd_byte[7];
                lk.bits  <= 4'd1;
                lk.st    <= ST_TX;
                addr     <= addr + ADDR_W'(1);
            end
        end
    end

    // Array update: every valid buffered byte lands in the current page at stop
    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (commit && pb_valid[i])
                mem[{addr[ADDR_W-1:PG_W], PG_W'(i)}] <= pb_data[i];
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sda_oe);
    p_quiet_while_busy_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);
    p_gate_protect_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!wp_i));
    p_gate_supply_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(supply_ok_i));
    p_hold_scl_high_r10: assert property (@(posedge clk) disable iff (rst)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));
endmodule

// File: tb/ee_i2c_slave_tb_top.sv
module ee_i2c_slave_tb_top;
    localparam int WR = 600;
    localparam int H  = 10;
    localparam int Q  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0, sup = 1'b1;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0, fails = 0, r10_viol = 0;
    logic [7:0] ref_mem [2048];
    logic scl_prev = 1'b1, oe_prev = 1'b0;

    always #2 clk = ~clk;

    ee_i2c_slave #(.WR_CYCLES(WR)) dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .wp_i(wp), .supply_ok_i(sup), .sda_oe(sda_oe)
    );

    // R10 monitor: the slave's drive must not move while SCL stays high
    always @(negedge clk) begin
        if (!rst && scl_m && scl_prev && (sda_oe != oe_prev))
            r10_viol++;
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(logic [10:0] a, int k, int seed);
        return 8'((int'(a) + k) * 37 + seed * 11 + 1);
    endfunction

    function automatic logic [7:0] dev(logic [10:0] a, logic rw);
        return {4'b1010, a[10:8], rw};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(Q);
        end
        sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H);
        ack = !sda_line;
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        for (int i = 7; i >= 0; i--) begin
            wt(H); scl_m = 1'b1; wt(H); b[i] = sda_line; scl_m = 1'b0; wt(Q);
        end
        sda_m = !mack; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(Q);
        sda_m = 1'b1;
    endtask

    task automatic page_write(logic [10:0] a, int n, int seed, bit lands, string tag);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(dev(a, 1'b0), ack); chk({tag, " R2 select ack"}, ack, 1);
        send_byte(a[7:0], ack);       chk({tag, " R3 word addr ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            d = pat(a, k, seed);
            send_byte(d, ack); chk({tag, " data ack"}, ack, 1);
            if (lands) ref_mem[{a[10:4], 4'(a[3:0] + k)}] = d;
        end
        bus_stop();
    endtask

    task automatic read_seq(logic [10:0] a, int n, string tag);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(dev(a, 1'b0), ack);
        send_byte(a[7:0], ack);
        bus_start();
        send_byte(dev(a, 1'b1), ack); chk({tag, " R3 read select ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(d, k != n - 1);
            chk({tag, " read data"}, d, ref_mem[11'(int'(a) + k)]);
        end
        bus_stop();
        chk({tag, " R6 released after NACK"}, sda_oe, 0);
    endtask

    task automatic poll(output logic ack);
        bus_start();
        send_byte(dev(11'h000, 1'b0), ack);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic ack;
        logic [10:0] a;
        int blks [4] = '{0, 2, 5, 7};
        wt(5); rst = 1'b0; wt(5);
        chk("R1 idle release", sda_oe, 0);

        // R3/R4 sweep: a wrapped full page in several address blocks
        foreach (blks[j]) begin
            a = 11'(blks[j] * 256 + blks[j] * 16 + 5);
            page_write(a, 16, blks[j], 1'b1, "R4 sweep");
            wt(WR + 50);
            read_seq({a[10:4], 4'h0}, 16, "R3 sweep");
        end

        // R4: 18 bytes overflow the page, first two offsets overwritten
        page_write(11'h123, 18, 9, 1'b1, "R4 overflow");
        wt(WR + 50);
        read_seq(11'h120, 16, "R4 overflow");

        // R7: programming interval hides the device, then it returns
        page_write(11'h7FF, 1, 3, 1'b1, "R7 write");
        poll(ack); chk("R7 busy NACK", ack, 0);
        wt(WR + 50);
        poll(ack); chk("R7 ACK after interval", ack, 1);

        // R6: read rollover from the top of the array
        read_seq(11'h7FF, 3, "R6 rollover");

        // R5: repeated start before stop discards buffered bytes
        bus_start();
        send_byte(dev(11'h224, 1'b0), ack);
        send_byte(8'h24, ack);
        send_byte(8'hC3, ack); chk("R5 data ack", ack, 1);
        send_byte(8'h3C, ack);
        read_seq(11'h224, 2, "R5 discard");
        poll(ack); chk("R5 no interval", ack, 1);

        // R8: write protect keeps old data and starts no interval
        wp = 1'b1;
        page_write(11'h123, 4, 77, 1'b0, "R8 protected");
        poll(ack); chk("R8 no interval", ack, 1);
        wp = 1'b0;
        read_seq(11'h120, 16, "R8 unchanged");

        // R9: supply lockout blocks the same way
        sup = 1'b0;
        page_write(11'h22A, 5, 55, 1'b0, "R9 lockout");
        poll(ack); chk("R9 no interval", ack, 1);
        sup = 1'b1;
        read_seq(11'h220, 16, "R9 unchanged");

        // R2: foreign device codes get no acknowledge
        bus_start();
        send_byte(8'b1011_0000, ack); chk("R2 code 1011 NACK", ack, 0);
        send_byte(8'h00, ack);        chk("R2 stays silent", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'b0010_1111, ack); chk("R2 code 0010 NACK", ack, 0);
        bus_stop();

        chk("R10 drive steady while SCL high", r10_viol, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule